// File: doc/BRIEF.md
# Synchronous USB Bridge FIFO Master

This block lives inside the FPGA and acts as the master of the synchronous slave FIFO bus of an external USB 2.0 bridge. Everything it does is timed by the 48 MHz interface clock that the bridge supplies. It reads 16-bit words from the bridge's host-to-device FIFO and passes them to a local receive stream. It also takes words from a local transmit stream and writes them into the bridge's device-to-host FIFO. Both local streams use valid/ready handshakes.

The two directions share one bus and one pair of status flags. The flags always describe whichever FIFO the address lines currently select. A round-robin controller therefore alternates between a drain phase and a fill phase. Each phase is bounded by a burst budget. Every change of address is followed by one idle cycle before any flag is used or any strobe is issued.

On the transmit side, a word counter tracks the current packet against the packet limit: 256 words at high speed and 32 words at full speed. When a message ends part way through a packet, the block commits that short packet with a packet-end strobe.

Top module: `usbfifo_master`

## Requirements
- R1: While reset is asserted, the read, write, output-enable and packet-end strobes are all high (inactive), and the block does not drive the data bus (`fd_oe` = 0).
- R2: A read strobe occurs only when `fifo_addr` = 2'b00 (the host-to-device FIFO). That address must also have been present in the previous cycle, and `sloe_n` must have been low in the previous cycle. Words reach `rx_data` in the order the bridge holds them.
- R3: The read strobe is never low while `bus_empty` is high, and the write strobe is never low while `bus_full` is high.
- R4: A read strobe occurs exactly when `rx_valid` and `rx_ready` are both high, and `rx_data` equals the bus word at that time. While `rx_ready` is low, no read is strobed.
- R5: A write strobe occurs exactly when `tx_valid` and `tx_ready` are both high. At that time `fifo_addr` = 2'b10 (the device-to-host FIFO), that address was also present in the previous cycle, and `fd_out` carries `tx_data`.
- R6: `fd_oe` is never high in a cycle where `sloe_n` is low.
- R7: If the last word of a message leaves a partial packet (length mod limit is nonzero), `pktend_n` pulses low for exactly one cycle, in the cycle right after that word's write. No packet-end occurs at any other time.
- R8: The packet limit is 256 words when `hs_mode` = 1 and 32 words when `hs_mode` = 0. A message whose length is an exact multiple of the limit produces no packet-end pulse.
- R9: Neither direction moves more than BURST_WORDS (default 16) words under one address selection before the other direction gets a turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock supplied by the bridge |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode | input | 1 | 1 selects the high-speed packet limit, 0 the full-speed limit |
| fifo_addr | output | 2 | FIFO select: 2'b00 host-to-device, 2'b10 device-to-host |
| fd_in | input | 16 | Data bus as driven by the bridge |
| fd_out | output | 16 | Data bus value driven by the block |
| fd_oe | output | 1 | High when the block drives the data bus |
| sloe_n | output | 1 | Active-low request for the bridge to drive the bus |
| slrd_n | output | 1 | Active-low read strobe |
| slwr_n | output | 1 | Active-low write strobe |
| pktend_n | output | 1 | Active-low packet-end (short packet commit) strobe |
| bus_full | input | 1 | Full flag of the selected FIFO |
| bus_empty | input | 1 | Empty flag of the selected FIFO |
| rx_data | output | 16 | Receive stream data |
| rx_valid | output | 1 | Receive stream valid |
| rx_ready | input | 1 | Receive stream ready |
| tx_data | input | 16 | Transmit stream data |
| tx_valid | input | 1 | Transmit stream valid |
| tx_last | input | 1 | Marks the final word of a transmit message |
| tx_ready | output | 1 | Transmit stream ready |

## Verification
The bench sweeps message lengths around the packet limits in both speed modes: one word, limit minus one, exactly the limit, limit plus one, and twice the limit. A counter that commits short packets at the wrong length would emit a packet-end after a packet-sized message, or miss one after a message of limit plus one. Backpressure on both streams and a small, slowly drained device-to-host FIFO force the flags to toggle mid-burst. A design that strobes on a stale flag would overfill or over-read the bridge model. Every read and write is also checked against the address that was present one cycle earlier. This exposes a controller that skips the settle cycle, or that lets one direction run past its burst budget.

// File: rtl/usbfifo_pkg.sv
package usbfifo_pkg;

    localparam int DATA_W = 16;
    localparam logic [1:0] ADDR_OUT = 2'b00;
    localparam logic [1:0] ADDR_IN  = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL_RX,
        ST_RX,
        ST_SEL_TX,
        ST_TX,
        ST_PKTEND
    } ctrl_st_e;

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic       pe;
        logic       oe_req;
        logic       drive;
        logic [1:0] addr;
    } bus_ctl_t;

    function automatic bus_ctl_t decode_bus(ctrl_st_e st, logic rd_fire, logic wr_fire);
        bus_ctl_t c;
        c.rd     = rd_fire;
        c.wr     = wr_fire;
        c.pe     = (st == ST_PKTEND);
        c.oe_req = (st == ST_SEL_RX) || (st == ST_RX);
        c.drive  = (st == ST_SEL_TX) || (st == ST_TX) || (st == ST_PKTEND);
        c.addr   = c.drive ? ADDR_IN : ADDR_OUT;
        return c;
    endfunction

endpackage

// File: rtl/usbfifo_pktcnt.sv
module usbfifo_pktcnt #(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] lim,
    input  logic          wr,
    input  logic          last,
    output logic          pe_need
);
    logic [LW-1:0] cnt;
    logic [LW-1:0] nxt;

    assign nxt     = cnt + LW'(1);
    assign pe_need = wr && last && (nxt != lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr) begin
            cnt <= (last || nxt == lim) ? '0 : nxt;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt < lim); // R8

endmodule

// File: rtl/usbfifo_ctrl.sv
module usbfifo_ctrl
    import usbfifo_pkg::*;
#(
    parameter int BURST_WORDS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bus_empty,
    input  logic     bus_full,
    input  logic     rx_ready,
    input  logic     tx_valid,
    input  logic     tx_last,
    input  logic     pe_need,
    output ctrl_st_e st,
    output logic     rd_fire,
    output logic     wr_fire
);
    localparam int BW = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
    localparam logic [BW-1:0] BLAST = BW'(BURST_WORDS - 1);

    ctrl_st_e      st_n;
    logic [BW-1:0] bcnt, bcnt_n;

    assign rd_fire = (st == ST_RX) && !bus_empty && rx_ready;
    assign wr_fire = (st == ST_TX) && tx_valid && !bus_full;

    always_comb begin
        st_n   = st;
        bcnt_n = bcnt;
        unique case (st)
            ST_IDLE:   st_n = ST_SEL_RX;
            ST_SEL_RX: begin st_n = ST_RX; bcnt_n = '0; end
            ST_RX: begin
                if (rd_fire) bcnt_n = bcnt + BW'(1);
                if (!rd_fire || bcnt == BLAST) st_n = ST_SEL_TX;
            end
            ST_SEL_TX: begin st_n = ST_TX; bcnt_n = '0; end
            ST_TX: begin
                if (wr_fire) bcnt_n = bcnt + BW'(1);
                if (wr_fire && tx_last)
                    st_n = pe_need ? ST_PKTEND : ST_SEL_RX;
                else if (!wr_fire || bcnt == BLAST)
                    st_n = ST_SEL_RX;
            end
            ST_PKTEND: st_n = ST_SEL_RX;
            default:   st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            bcnt <= '0;
        end else begin
            st   <= st_n;
            bcnt <= bcnt_n;
        end
    end

    AST_RX_AFTER_SELECT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RX) |-> ($past(st) == ST_SEL_RX || $past(st) == ST_RX)); // R2

    AST_TX_AFTER_SELECT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TX) |-> ($past(st) == ST_SEL_TX || $past(st) == ST_TX)); // R5

endmodule

// File: rtl/usbfifo_master.sv
module usbfifo_master
    import usbfifo_pkg::*;
#(
    parameter int HS_WORDS    = 256,
    parameter int FS_WORDS    = 32,
    parameter int BURST_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_mode,
    output logic [1:0]        fifo_addr,
    input  logic [DATA_W-1:0] fd_in,
    output logic [DATA_W-1:0] fd_out,
    output logic              fd_oe,
    output logic              sloe_n,
    output logic              slrd_n,
    output logic              slwr_n,
    output logic              pktend_n,
    input  logic              bus_full,
    input  logic              bus_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_last,
    output logic              tx_ready
);
    localparam int LW = $clog2(HS_WORDS + 1);

    ctrl_st_e      st;
    logic          rd_fire, wr_fire, pe_need;
    logic [LW-1:0] lim;
    bus_ctl_t      ctl;

    assign lim = hs_mode ? LW'(HS_WORDS) : LW'(FS_WORDS);

    usbfifo_ctrl #(.BURST_WORDS(BURST_WORDS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .bus_empty(bus_empty),
        .bus_full (bus_full),
        .rx_ready (rx_ready),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .pe_need  (pe_need),
        .st       (st),
        .rd_fire  (rd_fire),
        .wr_fire  (wr_fire)
    );

    usbfifo_pktcnt #(.LW(LW)) u_pktcnt (
        .clk    (clk),
        .rst    (rst),
        .lim    (lim),
        .wr     (wr_fire),
        .last   (tx_last),
        .pe_need(pe_need)
    );

    assign ctl       = decode_bus(st, rd_fire, wr_fire);
    assign fifo_addr = ctl.addr;
    assign sloe_n    = !ctl.oe_req;
    assign slrd_n    = !ctl.rd;
    assign slwr_n    = !ctl.wr;
    assign pktend_n  = !ctl.pe;
    assign fd_oe     = ctl.drive;
    assign fd_out    = tx_data;

    assign rx_data   = fd_in;
    assign rx_valid  = (st == ST_RX) && !bus_empty;
    assign tx_ready  = (st == ST_TX) && !bus_full;

    AST_RD_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !slrd_n |-> !bus_empty); // R3
    AST_WR_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        !slwr_n |-> !bus_full); // R3
    AST_OE_LEADS_READ: assert property (@(posedge clk) disable iff (rst)
        !slrd_n |-> $past(!sloe_n)); // R2
    AST_ADDR_SETTLED: assert property (@(posedge clk) disable iff (rst)
        (!slrd_n || !slwr_n || !pktend_n) |-> $stable(fifo_addr)); // R2
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        fd_oe |-> sloe_n); // R6
    AST_RD_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        !slrd_n |-> rx_ready); // R4
    AST_PE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        !pktend_n |-> $past(!slwr_n && tx_last)); // R7
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({!slrd_n, !slwr_n, !pktend_n}) <= 1); // R5

endmodule

// File: tb/sim_usbfifo_master.sv
module sim_usbfifo_master;
    localparam int N_OUT  = 300;
    localparam int IN_CAP = 40;
    localparam int BURST  = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs = 1'b1;
    logic [1:0]  fifo_addr;
    logic [15:0] fd_in, fd_out, rx_data, tx_data;
    logic        fd_oe, sloe_n, slrd_n, slwr_n, pktend_n;
    logic        bus_full, bus_empty, rx_valid, rx_ready, tx_valid, tx_last, tx_ready;
    logic [15:0] lfsr = 16'hACE1;

    int n_chk = 0, n_bad = 0;
    int rd_idx, m, p, in_lvl, in_pkt, rd_run, wr_run, pe_seen, pe_len;
    bit pe_pend, pe_exp, done;
    logic [1:0] prev_addr;
    logic       prev_oe_n;

    always #10 clk = ~clk;

    usbfifo_master u0 (
        .clk(clk), .rst(rst), .hs_mode(hs), .fifo_addr(fifo_addr),
        .fd_in(fd_in), .fd_out(fd_out), .fd_oe(fd_oe), .sloe_n(sloe_n),
        .slrd_n(slrd_n), .slwr_n(slwr_n), .pktend_n(pktend_n),
        .bus_full(bus_full), .bus_empty(bus_empty),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    function automatic int msg_len(bit h, int i);
        if (h) begin
            case (i)
                0: return 1;   1: return 255; 2: return 256; 3: return 257;
                4: return 3;   5: return 512; 6: return 511;
                default: return 0;
            endcase
        end
        return i + 1;
    endfunction

    function automatic int n_msgs(bit h);
        return h ? 7 : 70;
    endfunction

    function automatic int limit(bit h);
        return h ? 256 : 32;
    endfunction

    function automatic logic [15:0] out_word(int i);
        return 16'(i * 257 + 17);
    endfunction

    function automatic logic [15:0] tx_word(int mi, int pi);
        return 16'(mi * 613 + pi * 7 + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bridge and stream models
    assign fd_in     = (!sloe_n && fifo_addr == 2'b00 && rd_idx < N_OUT) ? out_word(rd_idx) : 16'hDEAD;
    assign bus_empty = (fifo_addr == 2'b00) ? (rd_idx >= N_OUT) : (in_lvl == 0);
    assign bus_full  = (fifo_addr == 2'b10) ? (in_lvl >= IN_CAP) : 1'b0;
    assign tx_valid  = (m < n_msgs(hs)) && (lfsr[0] | lfsr[3]);
    assign tx_data   = tx_word(m, p);
    assign tx_last   = (p == msg_len(hs, m) - 1);
    assign rx_ready  = lfsr[5] | lfsr[1] | lfsr[9];
    assign done      = (rd_idx == N_OUT) && (m == n_msgs(hs)) && !pe_pend;

    initial forever begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    always @(posedge clk) begin
        if (rst) begin
            rd_idx <= 0; m <= 0; p <= 0; in_lvl <= 0; in_pkt <= 0;
            rd_run <= 0; wr_run <= 0; pe_seen <= 0; pe_pend <= 0; pe_exp <= 0; pe_len <= 0;
            prev_addr <= 2'b00; prev_oe_n <= 1'b1;
        end else begin
            int lvl_n;
            int L;
            lvl_n = in_lvl;
            L = msg_len(hs, m);
            check(!(fd_oe && !sloe_n), "R6 bus contention", {fd_oe, sloe_n}, 2'b01);

            if (!slrd_n) begin
                check(rd_idx < N_OUT, "R3 read while empty", rd_idx, N_OUT - 1);
                check(rx_valid && rx_ready && rx_data == out_word(rd_idx), "R4 receive word",
                      rx_data, out_word(rd_idx));
                check(fifo_addr == 2'b00 && prev_addr == 2'b00 && !prev_oe_n, "R2 read setup",
                      {prev_oe_n, prev_addr, fifo_addr}, 0);
                check(rd_run + 1 <= BURST, "R9 read burst", rd_run + 1, BURST);
                rd_idx <= rd_idx + 1;
                rd_run <= rd_run + 1;
            end else begin
                if (rx_valid && rx_ready) check(0, "R4 accept without read", 1, 0);
                if (fifo_addr != 2'b00) rd_run <= 0;
            end

            if (!slwr_n) begin
                check(in_lvl < IN_CAP, "R3 write while full", in_lvl, IN_CAP - 1);
                check(tx_valid && tx_ready && fd_oe && fd_out == tx_word(m, p), "R5 write data",
                      fd_out, tx_word(m, p));
                check(fifo_addr == 2'b10 && prev_addr == 2'b10, "R5 write address",
                      {prev_addr, fifo_addr}, 4'b1010);
                check(wr_run + 1 <= BURST, "R9 write burst", wr_run + 1, BURST);
                wr_run <= wr_run + 1;
                lvl_n = lvl_n + 1;
                if (in_pkt + 1 == limit(hs)) in_pkt <= 0;
                else in_pkt <= in_pkt + 1;
                if (p == L - 1) begin
                    pe_pend <= 1'b1;
                    pe_exp  <= (L % limit(hs)) != 0;
                    pe_len  <= L % limit(hs);
                    m <= m + 1;
                    p <= 0;
                end else begin
                    p <= p + 1;
                end
            end else begin
                if (tx_valid && tx_ready) check(0, "R5 accept without write", 1, 0);
                if (fifo_addr != 2'b10) wr_run <= 0;
            end

            if (pe_pend) begin
                pe_pend <= 1'b0;
                check((!pktend_n) == pe_exp, "R7/R8 packet-end after last word", !pktend_n, pe_exp);
                if (!pktend_n) begin
                    check(in_pkt == pe_len && fifo_addr == 2'b10, "R7 short packet length",
                          in_pkt, pe_len);
                    in_pkt  <= 0;
                    pe_seen <= pe_seen + 1;
                end
            end else if (!pktend_n) begin
                check(0, "R7 stray packet-end", 1, 0);
            end

            if (in_lvl > 0 && lfsr[7] && lfsr[2]) lvl_n = lvl_n - 1;
            in_lvl    <= lvl_n;
            prev_addr <= fifo_addr;
            prev_oe_n <= sloe_n;
        end
    end

    initial begin
        for (int ph = 0; ph < 2; ph++) begin
            int cyc;
            int exp_pe;
            hs  = (ph == 0);
            rst = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check(slrd_n && slwr_n && pktend_n && sloe_n && !fd_oe, "R1 reset state",
                  {slrd_n, slwr_n, pktend_n, sloe_n, fd_oe}, 5'b11110);
            rst = 1'b0;
            cyc = 0;
            while (!done && cyc < 60000) begin
                @(negedge clk);
                cyc++;
            end
            check(done, "R2/R5 watchdog, transfer incomplete", cyc, 60000);
            exp_pe = 0;
            for (int i = 0; i < n_msgs(hs); i++)
                if (msg_len(hs, i) % limit(hs) != 0) exp_pe++;
            check(pe_seen == exp_pe, "R8 packet-end count", pe_seen, exp_pe);
            check(rd_idx == N_OUT, "R2 words received", rd_idx, N_OUT);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule